// File: doc/BRIEF.md
# Split or Unified Event Counter

This block is the counting core of an event-driven timer. It holds a 32-bit count that can run as one wide counter or as two independent 16-bit halves, called low and high. Each half has its own divider, halt control, clear control and up/down mode. In the wide mode the low half's controls drive the whole count. The count values and a direction flag for each half go to downstream compare and waveform logic.

A limit condition for each half is the OR of the external event lines selected by that half's limit mask. When a half is not in bidirectional mode, a limit sends its count back to zero. In bidirectional mode, a limit turns the count downward, and the count turns upward again when it reaches zero. This gives center-aligned waveforms. Software programs the block through a simple write port and can read any register back through a combinational read port.

Top module: `split_event_counter`

## Requirements
- R1: After reset both halves are halted, both counts and both direction flags are zero, and split mode is selected. A read of a half-control register returns 0x1.
- R2: The register map uses these addresses: mode at 0 (bit 0 selects wide mode), low control at 1, high control at 2, low limit mask at 3, high limit mask at 4. In a half-control word, bit 0 is halt, bit 1 is clear, bit 2 is bidirectional, and bits 15:8 hold the divider value PRE. A running half advances once every PRE+1 clocks.
- R3: A half whose halt bit is set keeps its count. The halves run and stop independently in split mode.
- R4: Writing 1 to a clear bit forces that count and its direction flag to zero on the following clock edge. It also restarts the divider. This happens even while the half is halted.
- R5: With bidirectional mode off, an advance while any event line selected by the half's mask is high sends the count to zero. Event lines outside the mask have no effect.
- R6: The clear bit clears itself: one cycle after it is set, it reads back as 0, unless it is written again.
- R7: With bidirectional mode on, a limit on an upward advance sets the direction flag to 1 and the count steps down by one.
- R8: In bidirectional mode, an advance while counting down at zero sets the count to 1 and the direction flag to 0.
- R9: In wide mode the two halves form one 32-bit count, with the carry passing from low to high. The low control and low mask govern the whole count. The high halt and high clear have no effect, and both direction outputs show the shared direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| evt_i | input | 8 | Event lines feeding the limit masks |
| cnt_lo_o | output | 16 | Low half count (low bits of the wide count) |
| cnt_hi_o | output | 16 | High half count (high bits of the wide count) |
| dir_lo_o | output | 1 | Low half direction, 1 while counting down |
| dir_hi_o | output | 1 | High half direction, 1 while counting down |

## Verification
The assertions check the following on every cycle: a halted half holds its count, a clear zeroes the count and direction, the clear bit clears itself, a limit wraps or reverses the count according to mode, the divider never ticks on two cycles in a row when PRE is non-zero, and in wide mode the two direction outputs agree. The bench scenarios cover what the assertions cannot: exact count values against elapsed clocks for different dividers, the exact cycle at which a limit takes effect, the turn-around at zero, and the carry across the 16-bit boundary, which needs more than 65536 clocks of wide counting.

// File: rtl/sec_pkg.sv
package sec_pkg;
  localparam int PRE_W   = 8;
  localparam int PRE_LSB = 8;
  localparam int ADDR_W  = 3;

  localparam logic [ADDR_W-1:0] A_MODE   = 3'd0;
  localparam logic [ADDR_W-1:0] A_LO     = 3'd1;
  localparam logic [ADDR_W-1:0] A_HI     = 3'd2;
  localparam logic [ADDR_W-1:0] A_LOMASK = 3'd3;
  localparam logic [ADDR_W-1:0] A_HIMASK = 3'd4;

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic             bidir;
    logic             clr;
    logic             halt;
  } half_ctrl_t;
endpackage

// File: rtl/sec_rst_sync.sv
module sec_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/sec_regs.sv
module sec_regs
  import sec_pkg::*;
#(
  parameter int EV_N = 8,
  parameter int DW   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              unify_o,
  output half_ctrl_t        ctrl_o [2],
  output logic [EV_N-1:0]   mask_o [2],
  output logic [DW-1:0]     rd_data_o
);
  logic       unify_q, unify_d;
  half_ctrl_t ctrl_q [2];
  half_ctrl_t ctrl_d [2];
  logic [EV_N-1:0] mask_q [2];
  logic [EV_N-1:0] mask_d [2];
  logic       reg_en;

  function automatic half_ctrl_t unpack_ctrl(input logic [DW-1:0] w);
    half_ctrl_t c;
    c.pre   = w[PRE_LSB +: PRE_W];
    c.bidir = w[2];
    c.clr   = w[1];
    c.halt  = w[0];
    return c;
  endfunction

  function automatic logic [DW-1:0] pack_ctrl(input half_ctrl_t c);
    logic [DW-1:0] w;
    w = '0;
    w[0] = c.halt;
    w[1] = c.clr;
    w[2] = c.bidir;
    w[PRE_LSB +: PRE_W] = c.pre;
    return w;
  endfunction

  // next-state
  always_comb begin
    unify_d = unify_q;
    if (wr_en && wr_addr == A_MODE) unify_d = wr_data[0];
    for (int h = 0; h < 2; h++) begin
      ctrl_d[h]     = ctrl_q[h];
      ctrl_d[h].clr = 1'b0;
      mask_d[h]     = mask_q[h];
      if (wr_en && wr_addr == ADDR_W'(int'(A_LO) + h))
        ctrl_d[h] = unpack_ctrl(wr_data);
      if (wr_en && wr_addr == ADDR_W'(int'(A_LOMASK) + h))
        mask_d[h] = wr_data[EV_N-1:0];
    end
    reg_en = wr_en || ctrl_q[0].clr || ctrl_q[1].clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unify_q <= 1'b0;
      for (int h = 0; h < 2; h++) begin
        ctrl_q[h] <= '{pre: '0, bidir: 1'b0, clr: 1'b0, halt: 1'b1};
        mask_q[h] <= '0;
      end
    end else if (reg_en) begin
      unify_q <= unify_d;
      for (int h = 0; h < 2; h++) begin
        ctrl_q[h] <= ctrl_d[h];
        mask_q[h] <= mask_d[h];
      end
    end
  end

  always_comb begin
    case (rd_addr)
      A_MODE:   rd_data_o = {{(DW-1){1'b0}}, unify_q};
      A_LO:     rd_data_o = pack_ctrl(ctrl_q[0]);
      A_HI:     rd_data_o = pack_ctrl(ctrl_q[1]);
      A_LOMASK: rd_data_o = DW'(mask_q[0]);
      A_HIMASK: rd_data_o = DW'(mask_q[1]);
      default:  rd_data_o = '0;
    endcase
  end

  assign unify_o = unify_q;
  assign ctrl_o  = ctrl_q;
  assign mask_o  = mask_q;

  // R6
  clr_lo_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[0].clr && !(wr_en && wr_addr == A_LO)) |=> !ctrl_q[0].clr);

  // R6
  clr_hi_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[1].clr && !(wr_en && wr_addr == A_HI)) |=> !ctrl_q[1].clr);
endmodule

// File: rtl/sec_prescale.sv
module sec_prescale #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] pre_i,
  input  logic          hold_i,
  output logic          tick_o
);
  logic [PW-1:0] pcnt_q, pcnt_d;
  logic          pcnt_en;

  always_comb begin
    tick_o = !hold_i && (pcnt_q >= pre_i);
    if (hold_i || tick_o) pcnt_d = '0;
    else                  pcnt_d = pcnt_q + PW'(1);
    pcnt_en = hold_i ? (pcnt_q != '0) : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcnt_q <= '0;
    else if (pcnt_en) pcnt_q <= pcnt_d;
  end

  // R2
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && pre_i != '0) |=> (!tick_o || pre_i == '0));
endmodule

// File: rtl/sec_step.sv
module sec_step #(
  parameter int W = 16
) (
  input  logic [W-1:0] cnt_i,
  input  logic         dir_i,
  input  logic         bidir_i,
  input  logic         limit_i,
  input  logic         adv_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o,
  output logic         dir_o
);
  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] ZERO = '0;

  always_comb begin
    cnt_o = cnt_i;
    dir_o = dir_i;
    if (clr_i) begin
      cnt_o = ZERO;
      dir_o = 1'b0;
    end else if (adv_i) begin
      if (!bidir_i) begin
        dir_o = 1'b0;
        cnt_o = limit_i ? ZERO : cnt_i + ONE;
      end else if (!dir_i) begin
        if (limit_i) begin
          dir_o = 1'b1;
          cnt_o = (cnt_i == ZERO) ? ZERO : cnt_i - ONE;
        end else begin
          cnt_o = cnt_i + ONE;
        end
      end else begin
        if (cnt_i == ZERO) begin
          dir_o = 1'b0;
          cnt_o = ONE;
        end else begin
          cnt_o = cnt_i - ONE;
        end
      end
    end
  end
endmodule

// File: rtl/split_event_counter.sv
module split_event_counter
  import sec_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int EV_N   = 8,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DW-1:0]     rd_data,
  input  logic [EV_N-1:0]   evt_i,
  output logic [HALF_W-1:0] cnt_lo_o,
  output logic [HALF_W-1:0] cnt_hi_o,
  output logic              dir_lo_o,
  output logic              dir_hi_o
);
  localparam int FULL_W = 2 * HALF_W;

  logic            rst_n_s;
  logic            unify;
  half_ctrl_t      ctrl [2];
  logic [EV_N-1:0] mask [2];

  logic [HALF_W-1:0] cnt_q [2];
  logic [HALF_W-1:0] cnt_d [2];
  logic              dir_q [2];
  logic              dir_d [2];
  logic              cnt_en [2];

  logic              tick [2];
  logic              hold [2];
  logic              lim  [2];
  logic [HALF_W-1:0] half_nx [2];
  logic              half_dir_nx [2];

  logic [FULL_W-1:0] wide_nx;
  logic              wide_dir_nx;

  sec_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_n_s)
  );

  sec_regs #(.EV_N(EV_N), .DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .unify_o   (unify),
    .ctrl_o    (ctrl),
    .mask_o    (mask),
    .rd_data_o (rd_data)
  );

  for (genvar h = 0; h < 2; h++) begin : g_half
    if (h == 0) begin : g_gov
      assign hold[h] = ctrl[h].halt | ctrl[h].clr;
    end else begin : g_sub
      assign hold[h] = unify | ctrl[h].halt | ctrl[h].clr;
    end

    assign lim[h] = |(evt_i & mask[h]);

    sec_prescale #(.PW(PRE_W)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n_s),
      .pre_i  (ctrl[h].pre),
      .hold_i (hold[h]),
      .tick_o (tick[h])
    );

    sec_step #(.W(HALF_W)) u_step (
      .cnt_i   (cnt_q[h]),
      .dir_i   (dir_q[h]),
      .bidir_i (ctrl[h].bidir),
      .limit_i (lim[h]),
      .adv_i   (tick[h]),
      .clr_i   (ctrl[h].clr),
      .cnt_o   (half_nx[h]),
      .dir_o   (half_dir_nx[h])
    );
  end

  sec_step #(.W(FULL_W)) u_wide (
    .cnt_i   ({cnt_q[1], cnt_q[0]}),
    .dir_i   (dir_q[0]),
    .bidir_i (ctrl[0].bidir),
    .limit_i (lim[0]),
    .adv_i   (tick[0]),
    .clr_i   (ctrl[0].clr),
    .cnt_o   (wide_nx),
    .dir_o   (wide_dir_nx)
  );

  // next-state selection
  always_comb begin
    if (unify) begin
      cnt_d[0]  = wide_nx[HALF_W-1:0];
      cnt_d[1]  = wide_nx[FULL_W-1:HALF_W];
      dir_d[0]  = wide_dir_nx;
      dir_d[1]  = wide_dir_nx;
      cnt_en[0] = tick[0] | ctrl[0].clr;
      cnt_en[1] = tick[0] | ctrl[0].clr;
    end else begin
      for (int h = 0; h < 2; h++) begin
        cnt_d[h]  = half_nx[h];
        dir_d[h]  = half_dir_nx[h];
        cnt_en[h] = tick[h] | ctrl[h].clr;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      for (int h = 0; h < 2; h++) begin
        cnt_q[h] <= '0;
        dir_q[h] <= 1'b0;
      end
    end else begin
      for (int h = 0; h < 2; h++) begin
        if (cnt_en[h]) begin
          cnt_q[h] <= cnt_d[h];
          dir_q[h] <= dir_d[h];
        end
      end
    end
  end

  assign cnt_lo_o = cnt_q[0];
  assign cnt_hi_o = cnt_q[1];
  assign dir_lo_o = dir_q[0];
  assign dir_hi_o = dir_q[1];

  // R3
  halt_lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!unify && ctrl[0].halt && !ctrl[0].clr) |=> $stable(cnt_lo_o));

  // R3
  halt_hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!unify && ctrl[1].halt && !ctrl[1].clr) |=> $stable(cnt_hi_o));

  // R4
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    ctrl[0].clr |=> (cnt_lo_o == '0 && !dir_lo_o));

  // R5
  limit_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!unify && !ctrl[0].bidir && tick[0] && lim[0] && !ctrl[0].clr) |=> cnt_lo_o == '0);

  // R7
  limit_turn_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!unify && ctrl[0].bidir && tick[0] && lim[0] && !dir_lo_o && !ctrl[0].clr) |=> dir_lo_o);

  // R9
  wide_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (unify && ctrl[0].halt && !ctrl[0].clr) |=> ($stable(cnt_lo_o) && $stable(cnt_hi_o)));

  // R9
  wide_dir_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (unify && cnt_en[0]) |=> (dir_lo_o == dir_hi_o));
endmodule

// File: tb/split_event_counter_test.sv
`timescale 1ns/100ps
module split_event_counter_test;
  localparam int HW   = 16;
  localparam int EVN  = 8;
  localparam int S_LO = 0, S_HI = 1, S_DLO = 2, S_DHI = 3, S_RD = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en;
  logic [2:0]    wr_addr;
  logic [31:0]   wr_data;
  logic [2:0]    rd_addr;
  logic [31:0]   rd_data;
  logic [EVN-1:0] evt;
  logic [HW-1:0] cnt_lo, cnt_hi;
  logic          dir_lo, dir_hi;

  always #2.5 clk = ~clk;

  split_event_counter uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .evt_i(evt),
    .cnt_lo_o(cnt_lo), .cnt_hi_o(cnt_hi), .dir_lo_o(dir_lo), .dir_hi_o(dir_hi)
  );

  typedef struct {
    int          due;
    int          sel;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  function automatic logic [31:0] actual(input int sel);
    case (sel)
      S_LO:    return 32'(cnt_lo);
      S_HI:    return 32'(cnt_hi);
      S_DLO:   return 32'(dir_lo);
      S_DHI:   return 32'(dir_hi);
      default: return rd_data;
    endcase
  endfunction

  // monitor: compares results shortly after each rising edge
  always @(posedge clk) begin
    item_t it;
    cyc = cyc + 1;
    #1;
    while (q.size() > 0 && q[0].due <= cyc) begin
      it = q.pop_front();
      n_chk++;
      if (actual(it.sel) !== it.exp) begin
        n_bad++;
        $display("FAIL %s sel=%0d cycle=%0d actual=%0h expected=%0h",
                 it.req, it.sel, cyc, actual(it.sel), it.exp);
      end
    end
  end

  task automatic expect_at(input int due, input int sel, input logic [31:0] e, input string r);
    q.push_back('{due, sel, e, r});
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_to(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  function automatic logic [31:0] cw(input bit halt, input bit clr, input bit bidir, input int pre);
    return {16'd0, 8'(pre), 5'd0, bidir, clr, halt};
  endfunction

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int c0;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = 3'd1; evt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    c0 = cyc;
    expect_at(c0 + 1, S_LO,  32'd0, "R1");
    expect_at(c0 + 1, S_HI,  32'd0, "R1");
    expect_at(c0 + 1, S_DLO, 32'd0, "R1");
    expect_at(c0 + 1, S_RD,  32'h1, "R1");
    wait_to(c0 + 2);

    // R2 divider of one on low half, R3 high half stays halted
    wr(3'd1, cw(1, 1, 0, 0));
    wr(3'd1, cw(0, 0, 0, 0));
    c0 = cyc;
    expect_at(c0 + 5, S_LO, 32'd5, "R2");
    expect_at(c0 + 5, S_HI, 32'd0, "R3");
    wait_to(c0 + 6);
    wr(3'd1, cw(1, 0, 0, 0));
    c0 = cyc;
    expect_at(c0 + 3, S_LO, 32'd7, "R3");
    wait_to(c0 + 4);

    // R2 divider of three on high half, low stays frozen (R3)
    wr(3'd2, cw(1, 1, 0, 0));
    wr(3'd2, cw(0, 0, 0, 2));
    c0 = cyc;
    expect_at(c0 + 8, S_HI, 32'd2, "R2");
    expect_at(c0 + 9, S_HI, 32'd3, "R2");
    expect_at(c0 + 9, S_LO, 32'd7, "R3");
    wait_to(c0 + 10);
    wr(3'd2, cw(1, 0, 0, 2));

    // R4 clear while halted, R6 clear bit reads back zero
    wr(3'd1, cw(1, 1, 0, 0));
    c0 = cyc;
    expect_at(c0 + 1, S_RD, 32'h1, "R6");
    expect_at(c0 + 1, S_LO, 32'd0, "R4");
    wait_to(c0 + 2);

    // R5 limit wrap, unmasked line ignored
    wr(3'd3, 32'h1);
    wr(3'd1, cw(0, 0, 0, 0));
    c0 = cyc;
    expect_at(c0 + 3, S_LO, 32'd3, "R5");
    expect_at(c0 + 5, S_LO, 32'd0, "R5");
    expect_at(c0 + 6, S_LO, 32'd1, "R5");
    wait_to(c0 + 2); evt = 8'h02;
    wait_to(c0 + 4); evt = 8'h01;
    wait_to(c0 + 5); evt = 8'h00;
    wait_to(c0 + 6);
    wr(3'd1, cw(1, 1, 0, 0));

    // R7 / R8 bidirectional turn-around
    wr(3'd1, cw(0, 0, 1, 0));
    c0 = cyc;
    expect_at(c0 + 4, S_LO,  32'd2, "R7");
    expect_at(c0 + 4, S_DLO, 32'd1, "R7");
    expect_at(c0 + 6, S_LO,  32'd0, "R8");
    expect_at(c0 + 6, S_DLO, 32'd1, "R8");
    expect_at(c0 + 7, S_LO,  32'd1, "R8");
    expect_at(c0 + 7, S_DLO, 32'd0, "R8");
    expect_at(c0 + 8, S_LO,  32'd2, "R8");
    wait_to(c0 + 3); evt = 8'h01;
    wait_to(c0 + 4); evt = 8'h00;
    wait_to(c0 + 9);
    wr(3'd1, cw(1, 1, 0, 0));

    // R9 wide mode with carry; high halt and high clear ignored
    wr(3'd0, 32'h1);
    wr(3'd1, cw(1, 1, 0, 0));
    wr(3'd1, cw(0, 0, 0, 0));
    c0 = cyc;
    expect_at(c0 + 65539, S_LO,  32'd3, "R9");
    expect_at(c0 + 65539, S_HI,  32'd1, "R9");
    expect_at(c0 + 65539, S_DHI, 32'd0, "R9");
    wait_to(c0 + 100);
    wr(3'd2, cw(1, 1, 0, 0));
    wait_to(c0 + 65541);

    if (!done) begin
      done = 1;
      summary();
      $finish;
    end
  end
endmodule